// File: doc/BRIEF.md
# Sprite Attribute Memory Port

This block gives a processor byte-wide access to a 544-byte sprite attribute store. The store has a 512-byte main table of 16-bit entries and a 32-byte auxiliary table. A 10-bit byte pointer is set from a 9-bit word address, which software writes as a low byte and a high byte. Each data access then moves the pointer on by one. The high address byte also carries a priority-rotation flag. That flag goes straight out to the sprite logic.

A main-table entry must never show half old and half new data. For that reason, writes into the main table are staged. The even byte is only held in a latch. The odd byte then commits the latched byte and the new byte in two consecutive memory cycles. The auxiliary table takes each byte as it arrives. Pointer values from 0x220 to 0x3FF fold back onto the 32 auxiliary bytes. Reads return data one cycle after they are accepted, and they refresh the latch whenever they start at an even pointer. The memory itself sits outside the block behind a synchronous byte port.

Top module: `sam_port`

## Requirements
- R1: After reset the pointer is 0, `prio_rotate` is 0, `bus_ready` is 1 and `bus_rvalid` is 0.
- R2: `bus_sel` 0 writes the low word-address byte and 1 writes the high one. Either write reloads the pointer as {high bit 0, low byte} shifted left by one, using the stored value of the other half. `bus_sel` 2 is the data port.
- R3: A write with `bus_sel` 1 sets `prio_rotate` to data bit 7. Data bits 6 to 1 of that write have no effect on the pointer or on the flag.
- R4: A data write at an even pointer below 0x200 only loads the latch. No memory cycle is issued and the stored bytes are unchanged.
- R5: A data write at an odd pointer below 0x200 writes the latch to the pointer with bit 0 cleared in the acceptance cycle. The new byte goes to the pointer in the next cycle, and `bus_ready` is low during that next cycle.
- R6: A data write at a pointer of 0x200 or above stores the byte at once, whatever the parity of the pointer.
- R7: A pointer of 0x200 or above addresses physical byte 0x200 plus pointer bits 4 to 0.
- R8: A data read returns the byte at the pointer's physical address, with `bus_rvalid` high one cycle after acceptance and `bus_ready` low in that cycle. A read at an even pointer also loads that byte into the latch.
- R9: Every accepted data access adds one to the pointer modulo 1024, so 0x3FF is followed by 0x000.
- R10: Reads with `bus_sel` 0, 1 or 3, and writes with `bus_sel` 3, are accepted but have no effect: no `bus_rvalid`, no memory cycle and no pointer change.
- R11: The memory port is synchronous. `mem_rdata` holds the byte that `mem_addr` pointed at in the previous cycle in which `mem_en` was high and `mem_we` was low, and every address driven is below 544.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | 0 low address, 1 high address, 2 data, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_ready | output | 1 | Request is accepted in a cycle where this is high |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 8 | Read data |
| prio_rotate | output | 1 | Priority-rotation flag |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 10 | Physical byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the request |

## Verification
The bench targets the cases that break entry atomicity, and checks the whole memory image after every access. It checks that an even write alone leaves memory untouched: a design that stores the byte early would show a half-updated entry. It checks that an odd write commits the latched byte and not the byte that was just written, and that the latched byte came from a preceding even read rather than a stale write. The other corner cases are:
- the fold of the upper pointer range onto the 32 auxiliary bytes, where a wrong mask would corrupt main-table bytes;
- the pointer wrap from 0x3FF to 0;
- the ignored bits of the high address byte;
- accesses to unused selects, which must leave the pointer where it is.

// File: rtl/sam_pkg.sv
package sam_pkg;
  // Register-bus select codes
  typedef enum logic [1:0] {
    RSEL_PTR_LO = 2'd0,
    RSEL_PTR_HI = 2'd1,
    RSEL_DATA   = 2'd2,
    RSEL_NONE   = 2'd3
  } rsel_e;

  // Port sequencer states
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PAIR2  = 2'd1,
    ST_RDWAIT = 2'd2
  } port_st_e;
endpackage

// File: rtl/sam_ptr.sv
module sam_ptr #(
  parameter int LOW_AW = 9,
  parameter int DW     = 8,
  localparam int PW    = LOW_AW + 1,
  localparam int HI_W  = LOW_AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          step,
  input  logic [DW-1:0] wdata,
  output logic [PW-1:0] ptr,
  output logic          prio
);
  logic [DW-1:0]   lo_q;
  logic [HI_W-1:0] hi_q;

  // Word address to byte pointer
  function automatic logic [PW-1:0] word_to_ptr(input logic [HI_W-1:0] hi,
                                                input logic [DW-1:0] lo);
    word_to_ptr = {hi, lo, 1'b0};
  endfunction

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    ptr_next = p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      ptr  <= '0;
      prio <= 1'b0;
    end else if (ld_lo) begin
      lo_q <= wdata;
      ptr  <= word_to_ptr(hi_q, wdata);
    end else if (ld_hi) begin
      hi_q <= wdata[HI_W-1:0];
      prio <= wdata[DW-1];
      ptr  <= word_to_ptr(wdata[HI_W-1:0], lo_q);
    end else if (step) begin
      ptr  <= ptr_next(ptr);
    end
  end
endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import sam_pkg::*;
#(
  parameter int LOW_AW = 9,
  parameter int HI_AW  = 5,
  parameter int DW     = 8,
  localparam int PW    = LOW_AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [1:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  input  logic [PW-1:0] ptr,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_ready,
  output logic          bus_rvalid,
  output logic [DW-1:0] bus_rdata,
  output logic          ld_lo,
  output logic          ld_hi,
  output logic          step,
  output logic          mem_en,
  output logic          mem_we,
  output logic [PW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          ev_direct_wr,
  output logic          ev_latch_only,
  output logic          ev_pair_first,
  output logic          ev_rd
);
  port_st_e      st;
  logic [DW-1:0] latch_q;
  logic [PW-1:0] pend_addr;
  logic [DW-1:0] pend_byte;
  logic          rd_even;

  logic acc, acc_data, upper, even;

  // Pointer to physical byte address, folding the upper range
  function automatic logic [PW-1:0] phys_of(input logic [PW-1:0] p);
    if (p[LOW_AW]) phys_of = {1'b1, {(LOW_AW-HI_AW){1'b0}}, p[HI_AW-1:0]};
    else           phys_of = p;
  endfunction

  function automatic logic [PW-1:0] pair_base(input logic [PW-1:0] p);
    pair_base = {p[PW-1:1], 1'b0};
  endfunction

  assign bus_ready  = (st == ST_IDLE);
  assign acc        = bus_req && bus_ready;
  assign acc_data   = acc && (bus_sel == RSEL_DATA);
  assign upper      = ptr[LOW_AW];
  assign even       = !ptr[0];

  assign ld_lo      = acc && bus_we && (bus_sel == RSEL_PTR_LO);
  assign ld_hi      = acc && bus_we && (bus_sel == RSEL_PTR_HI);
  assign step       = acc_data;

  assign ev_direct_wr  = acc_data && bus_we && upper;
  assign ev_latch_only = acc_data && bus_we && !upper && even;
  assign ev_pair_first = acc_data && bus_we && !upper && !even;
  assign ev_rd         = acc_data && !bus_we;

  assign bus_rvalid = (st == ST_RDWAIT);
  assign bus_rdata  = bus_rvalid ? mem_rdata : '0;

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (st == ST_PAIR2) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = pend_addr;
      mem_wdata = pend_byte;
    end else if (ev_direct_wr) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = phys_of(ptr);
      mem_wdata = bus_wdata;
    end else if (ev_pair_first) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = pair_base(ptr);
      mem_wdata = latch_q;
    end else if (ev_rd) begin
      mem_en    = 1'b1;
      mem_addr  = phys_of(ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      latch_q   <= '0;
      pend_addr <= '0;
      pend_byte <= '0;
      rd_even   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ev_pair_first) begin
            st        <= ST_PAIR2;
            pend_addr <= ptr;
            pend_byte <= bus_wdata;
          end else if (ev_rd) begin
            st      <= ST_RDWAIT;
            rd_even <= even;
          end
          if (ev_latch_only || (ev_direct_wr && even)) latch_q <= bus_wdata;
        end
        ST_PAIR2: st <= ST_IDLE;
        ST_RDWAIT: begin
          st <= ST_IDLE;
          if (rd_even) latch_q <= mem_rdata;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sam_port.sv
module sam_port #(
  parameter int LOW_AW = 9,
  parameter int HI_AW  = 5,
  parameter int DW     = 8,
  localparam int PW    = LOW_AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [1:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_ready,
  output logic          bus_rvalid,
  output logic [DW-1:0] bus_rdata,
  output logic          prio_rotate,
  output logic          mem_en,
  output logic          mem_we,
  output logic [PW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic [PW-1:0] ptr_q;
  logic ld_lo, ld_hi, step;
  logic ev_direct_wr, ev_latch_only, ev_pair_first, ev_rd;

  sam_ptr #(.LOW_AW(LOW_AW), .DW(DW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (ld_lo),
    .ld_hi (ld_hi),
    .step  (step),
    .wdata (bus_wdata),
    .ptr   (ptr_q),
    .prio  (prio_rotate)
  );

  sam_ctrl #(.LOW_AW(LOW_AW), .HI_AW(HI_AW), .DW(DW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_sel       (bus_sel),
    .bus_wdata     (bus_wdata),
    .ptr           (ptr_q),
    .mem_rdata     (mem_rdata),
    .bus_ready     (bus_ready),
    .bus_rvalid    (bus_rvalid),
    .bus_rdata     (bus_rdata),
    .ld_lo         (ld_lo),
    .ld_hi         (ld_hi),
    .step          (step),
    .mem_en        (mem_en),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .ev_direct_wr  (ev_direct_wr),
    .ev_latch_only (ev_latch_only),
    .ev_pair_first (ev_pair_first),
    .ev_rd         (ev_rd)
  );
endmodule

// File: rtl/sam_port_chk.sv
module sam_port_chk #(
  parameter int LOW_AW = 9,
  parameter int HI_AW  = 5,
  parameter int DW     = 8,
  localparam int PW    = LOW_AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_ready,
  input logic          bus_rvalid,
  input logic          prio_rotate,
  input logic          mem_en,
  input logic          mem_we,
  input logic [PW-1:0] mem_addr,
  input logic [PW-1:0] ptr_q,
  input logic          ld_hi,
  input logic          step,
  input logic          ev_latch_only,
  input logic          ev_pair_first,
  input logic          ev_rd
);
  localparam logic [PW-1:0] MEM_LIM = PW'((1 << LOW_AW) + (1 << HI_AW));

  // R9: pointer advances by one after each data access
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R5: second half of a paired commit follows at the next byte
  p_pair_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pair_first |=> (mem_en && mem_we && !bus_ready && (mem_addr == $past(mem_addr) + 1'b1)));

  // R4: latch-only writes issue no memory cycle
  p_latch_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_latch_only |-> !mem_en);

  // R8: data read answers one cycle later
  p_read_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd |=> (bus_rvalid && !bus_ready));

  // R10: read data only after an accepted data read
  p_rvalid_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(ev_rd));

  // R11: physical address stays inside the store
  p_addr_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr < MEM_LIM));

  // R3: flag changes only through a high-address write
  p_prio_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_hi |=> $stable(prio_rotate));
endmodule

bind sam_port sam_port_chk #(.LOW_AW(LOW_AW), .HI_AW(HI_AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_ready     (bus_ready),
  .bus_rvalid    (bus_rvalid),
  .prio_rotate   (prio_rotate),
  .mem_en        (mem_en),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .ptr_q         (ptr_q),
  .ld_hi         (ld_hi),
  .step          (step),
  .ev_latch_only (ev_latch_only),
  .ev_pair_first (ev_pair_first),
  .ev_rd         (ev_rd)
);

// File: tb/sam_port_test.sv
`timescale 1ns/1ps
module sam_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_ready, bus_rvalid, prio_rotate, mem_en, mem_we;
  logic [7:0] bus_rdata, mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic [9:0] mem_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  // Store behind the port, and the model's view of it
  logic [7:0] sim_mem [0:543];
  int exp_mem [0:543];
  int m_ptr = 0, m_lo = 0, m_hi = 0, m_prio = 0, m_latch = 0;

  always #4 clk = ~clk;

  sam_port uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .prio_rotate(prio_rotate),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en && mem_addr < 10'd544) begin
      if (mem_we) sim_mem[mem_addr] <= mem_wdata;
      mem_rdata <= sim_mem[mem_addr];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int where(input int p);
    return (p < 512) ? p : 512 + (p % 32);
  endfunction

  task automatic image(input string tag);
    int bad = 0, first = -1;
    for (int i = 0; i < 544; i++)
      if (int'(sim_mem[i]) != exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    chk({tag, " memory image mismatches"}, bad, 0);
    if (bad != 0) chk({tag, " first bad byte"}, int'(sim_mem[first]), exp_mem[first]);
  endtask

  // One register access; starts and ends just after a falling edge
  task automatic access(input string tag, input bit we, input int sel, input int d);
    bit long_op;
    int exp_rd = 0;
    chk({tag, " ready before access"}, int'(bus_ready), 1);
    long_op = (sel == 2) && (!we || (m_ptr < 512 && (m_ptr % 2) == 1));
    if (sel == 2 && !we) begin
      exp_rd = exp_mem[where(m_ptr)];
      if (m_ptr % 2 == 0) m_latch = exp_rd;
      m_ptr = (m_ptr + 1) % 1024;
    end else if (sel == 2) begin
      if (m_ptr >= 512) begin
        exp_mem[where(m_ptr)] = d;
        if (m_ptr % 2 == 0) m_latch = d;
      end else if (m_ptr % 2 == 0) begin
        m_latch = d;
      end else begin
        exp_mem[m_ptr - 1] = m_latch;
        exp_mem[m_ptr] = d;
      end
      m_ptr = (m_ptr + 1) % 1024;
    end else if (we && sel == 0) begin
      m_lo = d;
      m_ptr = (m_hi * 256 + m_lo) * 2;
    end else if (we && sel == 1) begin
      m_hi = d % 2;
      m_prio = d / 128;
      m_ptr = (m_hi * 256 + m_lo) * 2;
    end
    bus_req = 1'b1; bus_we = we; bus_sel = 2'(sel); bus_wdata = 8'(d);
    @(posedge clk); @(negedge clk);
    bus_req = 1'b0;
    chk({tag, " prio flag R3"}, int'(prio_rotate), m_prio);
    chk({tag, " ready after accept R5/R8"}, int'(bus_ready), long_op ? 0 : 1);
    chk({tag, " rvalid R8/R10"}, int'(bus_rvalid), (sel == 2 && !we) ? 1 : 0);
    if (sel == 2 && !we) chk({tag, " read data R8"}, int'(bus_rdata), exp_rd);
    if (long_op) begin
      @(posedge clk); @(negedge clk);
      chk({tag, " rvalid drops"}, int'(bus_rvalid), 0);
    end
    image(tag);
  endtask

  initial begin
    for (int i = 0; i < 544; i++) begin
      sim_mem[i] = 8'((i * 37 + 11) % 256);
      exp_mem[i] = (i * 37 + 11) % 256;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ready after reset", int'(bus_ready), 1);
    chk("R1 rvalid after reset", int'(bus_rvalid), 0);
    chk("R1 prio after reset", int'(prio_rotate), 0);
    access("R1 read at reset pointer", 0, 2, 0);
    access("R9 read next byte", 0, 2, 0);
    access("R2 low address 5", 1, 0, 5);
    access("R4 even lower write", 1, 2, 8'hA5);
    access("R5 odd lower write", 1, 2, 8'h5A);
    access("R2 low address 0x30", 1, 0, 8'h30);
    access("R8 even read loads latch", 0, 2, 0);
    access("R8 odd write uses read latch", 1, 2, 8'hC3);
    access("R2 high address 1", 1, 1, 8'h01);
    access("R2 low address 0", 1, 0, 8'h00);
    access("R6 upper even write", 1, 2, 8'h11);
    access("R6 upper odd write", 1, 2, 8'h22);
    access("R7 low address 0x10", 1, 0, 8'h10);
    access("R7 aliased write", 1, 2, 8'h33);
    access("R7 aliased read", 0, 2, 0);
    access("R3 high with flag", 1, 1, 8'h81);
    access("R2 low address 0xFF", 1, 0, 8'hFF);
    access("R7 top even write", 1, 2, 8'h44);
    access("R9 top odd write", 1, 2, 8'h55);
    access("R9 read after wrap", 0, 2, 0);
    access("R3 ignored high bits", 1, 1, 8'h7E);
    access("R4 even at 0x1FE", 1, 2, 8'h66);
    access("R5 odd at 0x1FF", 1, 2, 8'h77);
    access("R10 unused select write", 1, 3, 8'h99);
    access("R10 low select read", 0, 0, 0);
    access("R10 high select read", 0, 1, 0);
    access("R10 unused select read", 0, 3, 0);
    access("R10 pointer kept read", 0, 2, 0);
    access("R2 low address 0x40", 1, 0, 8'h40);
    for (int k = 0; k < 8; k++) access("R5 burst write", 1, 2, 8'hE0 + k);
    access("R2 low address 0x40 again", 1, 0, 8'h40);
    for (int k = 0; k < 4; k++) access("R11 burst read", 0, 2, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule